// File: doc/BRIEF.md
# Conversion Result FIFO with Debug Status

This block holds conversion results produced by one sampling sequencer until software collects them. Results enter at the tail of an eight-entry circular buffer. A read of the single data port takes the oldest entry off the head. Software can also read a status word at any time. It exposes the raw head and tail pointers and the full and empty flags, which helps when debugging a sequence that stalls or runs ahead.

Two error conditions are caught and held apart from the data path. A result that arrives while the buffer is full is dropped and raises a sticky overflow flag. A read taken while the buffer is empty returns zero and raises a sticky underflow flag. Software clears each flag by writing a 1 to its bit. A write of 0 leaves the flag as it is.

Top module: `res_fifo_dbg`

## Requirements
- R1: After reset the buffer is empty, both pointers are 0, both error flags are 0 and `pop_data_o` is 0. The status word therefore reads 8'h80.
- R2: Accepted pushes are returned by pops in arrival order. `pop_data_o` shows the oldest entry combinationally, and an accepted pop advances the head at the next clock edge.
- R3: The status word `stat_o` is laid out as follows. Bits [2:0] hold the head (the read pointer). Bits [5:3] hold the tail (the write pointer). Bit 6 is full and bit 7 is empty. All fields update one clock edge after the push or pop that changes them.
- R4: Full is set when 8 entries are held. Empty is set when 0 entries are held. The two are never set together.
- R5: A push while full is discarded. The tail pointer and the stored contents stay unchanged, and the overflow flag `ovf_o` is set at the next edge.
- R6: A pop while empty drives 0 on `pop_data_o`. It leaves both pointers unchanged, and the underflow flag `unf_o` is set at the next edge.
- R7: A clear write (`clr_we_i` high) with `clr_data_i[0]`=1 clears overflow and with `clr_data_i[1]`=1 clears underflow. A bit written as 0 has no effect. If a new error event and a clear of the same flag fall in the same cycle, the event wins.
- R8: Whether a push or pop is accepted depends on the occupancy before the cycle. A push and a pop together on a buffer that is neither empty nor full both succeed: each pointer advances by one and the occupancy is unchanged.
- R9: Both pointers wrap from 7 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push a conversion result |
| push_data_i | input | 12 | Result to push |
| pop_i | input | 1 | Pop the oldest result (data read) |
| pop_data_o | output | 12 | Oldest result, 0 when empty |
| stat_o | output | 8 | Status word: head, tail, full, empty |
| clr_we_i | input | 1 | Write strobe for the error-flag clear |
| clr_data_i | input | 2 | Write-1-to-clear bits: [0] overflow, [1] underflow |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
The occupancy counter is the single point of failure inside this block. If it drifts, the full or empty bit in the status word disagrees with the distance between the head and tail pointers on the very next edge. Soon after that, a push is wrongly dropped with a spurious overflow, or a pop returns zero with a spurious underflow. A pointer that advances wrongly shows up as a data mismatch on the next pop, because every popped value is compared against its expected value at the moment it is read. A sticky flag that clears itself or ignores its clear mask shows up at the flag port one edge after the write.

// File: rtl/res_fifo_pkg.sv
package res_fifo_pkg;
  localparam int unsigned DEF_DEPTH = 8;
  localparam int unsigned DEF_WIDTH = 12;
  // clear-mask bit positions
  localparam int unsigned CLR_OVF_IDX = 0;
  localparam int unsigned CLR_UNF_IDX = 1;
  localparam int unsigned CLR_W       = 2;
endpackage

// File: rtl/res_fifo_ptrs.sv
module res_fifo_ptrs #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic             push_acc_o,
  output logic             pop_acc_o,
  output logic [PTR_W-1:0] rptr_o,
  output logic [PTR_W-1:0] wptr_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] rptr_q, wptr_q;

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full_o     = (cnt_q == CNT_W'(DEPTH));
  assign empty_o    = (cnt_q == '0);
  assign push_acc_o = push_i & ~full_o;
  assign pop_acc_o  = pop_i & ~empty_o;
  assign rptr_o     = rptr_q;
  assign wptr_o     = wptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rptr_q <= '0;
      wptr_q <= '0;
    end else begin
      if (push_acc_o) wptr_q <= inc(wptr_q);
      if (pop_acc_o)  rptr_q <= inc(rptr_q);
      case ({push_acc_o, pop_acc_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/res_fifo_mem.sv
module res_fifo_mem #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 12,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [PTR_W-1:0] raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [WIDTH-1:0] q;
    always_ff @(posedge clk_i) begin
      if (we_i && (waddr_i == PTR_W'(g))) q <= wdata_i;
    end
    assign ent[g] = q;
  end

  assign rdata_o = ent[raddr_i];
endmodule

// File: rtl/res_fifo_errs.sv
module res_fifo_errs #(
  parameter int unsigned CLR_W   = 2,
  parameter int unsigned OVF_IDX = 0,
  parameter int unsigned UNF_IDX = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             full_i,
  input  logic             empty_i,
  input  logic             clr_we_i,
  input  logic [CLR_W-1:0] clr_data_i,
  output logic             ovf_o,
  output logic             unf_o
);
  logic ovf_q, unf_q, ovf_evt, unf_evt, ovf_clr, unf_clr;

  assign ovf_evt = push_i & full_i;
  assign unf_evt = pop_i & empty_i;
  assign ovf_clr = clr_we_i & clr_data_i[OVF_IDX];
  assign unf_clr = clr_we_i & clr_data_i[UNF_IDX];

  // event has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_evt | (ovf_q & ~ovf_clr);
      unf_q <= unf_evt | (unf_q & ~unf_clr);
    end
  end

  assign ovf_o = ovf_q;
  assign unf_o = unf_q;
endmodule

// File: rtl/res_fifo_dbg.sv
module res_fifo_dbg
  import res_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned WIDTH = DEF_WIDTH,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned STAT_W = 2 * PTR_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [WIDTH-1:0]  push_data_i,
  input  logic              pop_i,
  output logic [WIDTH-1:0]  pop_data_o,
  output logic [STAT_W-1:0] stat_o,
  input  logic              clr_we_i,
  input  logic [CLR_W-1:0]  clr_data_i,
  output logic              ovf_o,
  output logic              unf_o
);
  logic             push_acc, pop_acc, full, empty;
  logic [PTR_W-1:0] rptr, wptr;
  logic [WIDTH-1:0] rdata;

  res_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .push_acc_o (push_acc),
    .pop_acc_o  (pop_acc),
    .rptr_o     (rptr),
    .wptr_o     (wptr),
    .full_o     (full),
    .empty_o    (empty)
  );

  res_fifo_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
    .clk_i   (clk_i),
    .we_i    (push_acc),
    .waddr_i (wptr),
    .wdata_i (push_data_i),
    .raddr_i (rptr),
    .rdata_o (rdata)
  );

  res_fifo_errs #(
    .CLR_W   (CLR_W),
    .OVF_IDX (CLR_OVF_IDX),
    .UNF_IDX (CLR_UNF_IDX)
  ) u_errs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .full_i     (full),
    .empty_i    (empty),
    .clr_we_i   (clr_we_i),
    .clr_data_i (clr_data_i),
    .ovf_o      (ovf_o),
    .unf_o      (unf_o)
  );

  // empty read returns zero; pop_acc only gates the head advance
  assign pop_data_o = empty ? '0 : rdata;
  assign stat_o     = {empty, full, wptr, rptr};
endmodule

// File: rtl/res_fifo_dbg_chk.sv
module res_fifo_dbg_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 12,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned STAT_W = 2 * PTR_W + 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              push_i,
  input logic              pop_i,
  input logic [WIDTH-1:0]  pop_data_o,
  input logic [STAT_W-1:0] stat_o,
  input logic              clr_we_i,
  input logic [1:0]        clr_data_i,
  input logic              ovf_o,
  input logic              unf_o
);
  logic [PTR_W-1:0] head, tail;
  logic             full, empty;
  assign head  = stat_o[PTR_W-1:0];
  assign tail  = stat_o[2*PTR_W-1:PTR_W];
  assign full  = stat_o[2*PTR_W];
  assign empty = stat_o[2*PTR_W+1];

  // R4
  full_empty_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full && empty));
  // R5
  push_full_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full |=> ovf_o);
  // R5
  push_full_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full |=> $stable(tail));
  // R6
  pop_empty_unf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && empty |=> unf_o);
  // R6
  pop_empty_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty |-> pop_data_o == '0);
  // R6
  pop_empty_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && empty |=> $stable(head));
  // R7
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !(clr_we_i && clr_data_i[0]) |=> ovf_o);
  // R7
  ovf_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i && clr_data_i[0] && !(push_i && full) |=> !ovf_o);
  // R7
  unf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o && !(clr_we_i && clr_data_i[1]) |=> unf_o);
  // R7
  unf_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i && clr_data_i[1] && !(pop_i && empty) |=> !unf_o);
  // R8
  pair_occ_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_i && !full && !empty |=> !full && !empty);
endmodule

bind res_fifo_dbg res_fifo_dbg_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .push_i     (push_i),
  .pop_i      (pop_i),
  .pop_data_o (pop_data_o),
  .stat_o     (stat_o),
  .clr_we_i   (clr_we_i),
  .clr_data_i (clr_data_i),
  .ovf_o      (ovf_o),
  .unf_o      (unf_o)
);

// File: tb/tb_res_fifo_dbg.sv
`timescale 1ns/1ps
module tb_res_fifo_dbg;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_i = 1'b0;
  logic [11:0] push_data_i = '0;
  logic        pop_i = 1'b0;
  logic [11:0] pop_data_o;
  logic [7:0]  stat_o;
  logic        clr_we_i = 1'b0;
  logic [1:0]  clr_data_i = '0;
  logic        ovf_o, unf_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [11:0] exp_q[$];
  logic [2:0]  m_head = '0, m_tail = '0;
  bit          m_ovf = 0, m_unf = 0;

  always #2.5 clk_i = ~clk_i;

  res_fifo_dbg dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push_i), .push_data_i(push_data_i),
    .pop_i(pop_i), .pop_data_o(pop_data_o), .stat_o(stat_o),
    .clr_we_i(clr_we_i), .clr_data_i(clr_data_i), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_stat();
    int sz = exp_q.size();
    return {sz == 0, sz == 8, m_tail, m_head};
  endfunction

  // driver: applies one cycle, feeds the scoreboard model
  task automatic cyc(input bit psh, input logic [11:0] d, input bit pp,
                     input bit cwe, input logic [1:0] cd, input string r);
    int sz;
    @(negedge clk_i);
    push_i = psh; push_data_i = d; pop_i = pp; clr_we_i = cwe; clr_data_i = cd;
    #1;
    sz = exp_q.size();
    // monitor: compare the popped value against the queue head
    if (pp) begin
      if (sz > 0) chk(r, pop_data_o, exp_q[0]);
      else        chk("R6 empty read", pop_data_o, 0);
    end
    m_ovf = (psh && sz == 8) || (m_ovf && !(cwe && cd[0]));
    m_unf = (pp && sz == 0) || (m_unf && !(cwe && cd[1]));
    if (pp && sz > 0) begin void'(exp_q.pop_front()); m_head++; end
    if (psh && sz < 8) begin exp_q.push_back(d); m_tail++; end
    @(posedge clk_i);
    #1;
    push_i = 0; pop_i = 0; clr_we_i = 0; clr_data_i = '0;
    chk("R3 status", stat_o, exp_stat());
    chk("R7 ovf", ovf_o, m_ovf);
    chk("R7 unf", unf_o, m_unf);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1 stat", stat_o, 8'h80);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 unf", unf_o, 0);
    chk("R1 data", pop_data_o, 0);

    // R2 ordering
    cyc(1, 12'hA11, 0, 0, 2'b00, "R2");
    cyc(1, 12'hA22, 0, 0, 2'b00, "R2");
    cyc(1, 12'hA33, 0, 0, 2'b00, "R2");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 2'b00, "R2 order");

    // R4 fill to full
    for (int i = 0; i < 8; i++) cyc(1, 12'(12'h100 + i), 0, 0, 2'b00, "R4");
    chk("R4 full bit", stat_o[6], 1);
    // R5 push while full is dropped
    cyc(1, 12'hFFF, 0, 0, 2'b00, "R5");
    chk("R5 ovf set", ovf_o, 1);
    // R7 writing zero leaves flags, unf-only clear leaves ovf
    cyc(0, 0, 0, 1, 2'b00, "R7");
    chk("R7 zero write", ovf_o, 1);
    cyc(0, 0, 0, 1, 2'b10, "R7");
    chk("R7 other bit", ovf_o, 1);
    cyc(0, 0, 0, 1, 2'b01, "R7");
    chk("R7 ovf cleared", ovf_o, 0);
    // R5 contents intact after the dropped push
    for (int i = 0; i < 8; i++) cyc(0, 0, 1, 0, 2'b00, "R5 contents");
    chk("R4 empty bit", stat_o[7], 1);

    // R6 pop while empty
    cyc(0, 0, 1, 0, 2'b00, "R6");
    chk("R6 unf set", unf_o, 1);
    // R7 event beats same-cycle clear
    cyc(0, 0, 1, 1, 2'b10, "R7");
    chk("R7 set wins", unf_o, 1);
    cyc(0, 0, 0, 1, 2'b11, "R7");
    chk("R7 unf cleared", unf_o, 0);

    // push+pop on empty: push taken, pop underflows
    cyc(1, 12'h5A5, 1, 0, 2'b00, "R8 empty pair");
    cyc(0, 0, 0, 1, 2'b10, "R8");
    cyc(1, 12'h066, 0, 0, 2'b00, "R8");
    // R8 simultaneous push and pop keep occupancy
    for (int i = 0; i < 5; i++) cyc(1, 12'(12'h200 + i), 1, 0, 2'b00, "R8 pair");
    chk("R8 occupancy", exp_q.size(), 2);

    // R9 pointer wrap over many laps
    for (int i = 0; i < 20; i++) cyc(1, 12'(12'h300 + i * 7), 1, 0, 2'b00, "R9 wrap");
    for (int i = 0; i < 2; i++) cyc(0, 0, 1, 0, 2'b00, "R9 drain");
    chk("R9 empty", stat_o[7], 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule